// File: doc/BRIEF.md
# Serial Control Port Target with Strap-Selected Chip Address

This block is the target end of a four-wire serial control port. A host frames each transaction with an active-low latch line, toggles a serial clock and shifts commands in on a data input. Readback comes out on a separate data output that has its own output-enable, so several targets can share one return wire. Every frame begins with a header. The first byte holds a chip address and a direction bit. The next two bytes hold a 12-bit register index. Data bytes follow. The block turns each frame into single-cycle write or read strobes on a simple register-side interface. The register index advances by one for each further data byte.

After reset the port sits in its default two-wire mode, and it ignores serial frames. It moves into four-wire mode for good once the latch line has gone low three times. A one-bit strap picks which of two chip addresses the block answers to. This lets two targets share one latch line. All serial pins are taken into the core clock domain through synchronizers. The serial clock's edges are found by oversampling.

Top module: `spi_ctl_port`

## Requirements
- R1: Out of reset, `spiMode`, `sdoOe`, `regWrEn` and `regRdEn` are all low.
- R2: The port enters four-wire mode on the third falling edge of `latchN` and never leaves it. Frames whose latch fall comes before entry, the third pulse included, produce no strobes.
- R3: A write frame produces one `regWrEn` pulse per complete data byte, with `regAddr` and `regWrData` valid in that cycle. Byte 0 is `{chip[6:0], rw}` with rw=0 for a write, byte 1 bits 3:0 are index bits 11:8, byte 2 is index bits 7:0, and every field is sent most significant bit first, sampled on the rising edge of `sclk`.
- R4: Each further data byte in a frame goes to the previous index plus one, wrapping from 0xFFF to 0x000.
- R5: The block answers only to chip address 0x00 when `addrSel` is low and 0x01 when it is high. Any other address produces no strobe and leaves `sdoOe` low for the whole frame.
- R6: In a read frame (rw=1), `regRdEn` pulses with the header's index after the last index bit. The first byte of `regRdData` (valid the cycle after `regRdEn`) appears on `sdo`, MSB first, starting at the falling `sclk` edge that follows the last index bit.
- R7: During a read, after each 8th data clock the next index is fetched and its byte follows on `sdo` with no gap.
- R8: `sdoOe` is high only from the first read-data falling edge of a matching read frame until the latch rises, and it is low within four core cycles of `latchN` going high.
- R9: A frame that ends partway through a data byte discards that byte. Data bytes completed before the end are still written.
- R10: Bits 7:4 of byte 1 have no effect on the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| latchN | input | 1 | Frame latch, low during a transaction |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| addrSel | input | 1 | Strap picking chip address 0 or 1 |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for `sdo`; low means released |
| spiMode | output | 1 | High once four-wire mode is entered |
| regAddr | output | 12 | Register index for the current strobe |
| regWrEn | output | 1 | Register write strobe |
| regWrData | output | 8 | Write data, valid with `regWrEn` |
| regRdEn | output | 1 | Register read strobe |
| regRdData | input | 8 | Read data, valid the cycle after `regRdEn` |

## Verification
The assertions hold on every cycle for these properties:
- the mode never falls back once entered;
- no strobe and no output enable occur in two-wire mode;
- the write and read strobes never coincide;
- the output enable drops soon after the latch rises.

The bench scenarios are what show the remaining behaviour:
- that header fields are decoded to the right index and data;
- that the index advances and wraps;
- that a non-matching chip address or a truncated byte causes nothing;
- that readback bits arrive in order starting at the right falling edge.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  typedef struct packed {
    logic shiftIn;   // take one serial bit into the input shifter
    logic capHdr;    // first byte complete: latch chip match and direction
    logic capSub;    // last index bit: load the running index
    logic wrStb;     // full write data byte present
    logic fetch;     // issue register read at the running index
    logic capRd;     // capture register read data into the readback buffer
    logic loadOut;   // load readback buffer into the output shifter
    logic shiftOut;  // advance the output shifter
    logic oeSet;     // drive the data-out line
    logic clrFrame;  // latch high: end of frame
  } ctrlStrobes_t;

endpackage

// File: rtl/spi_ctl_fsm.sv
module spi_ctl_fsm
  import spi_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MODE_PULSES = 3,
  parameter int HDR_BITS    = 24,
  parameter int BYTE_W      = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         latchN,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         hdrMatch,
  input  logic         hdrRead,
  output logic         sdiQ,
  output logic         spiMode,
  output ctrlStrobes_t strb
);

  localparam int CNT_W  = $clog2(HDR_BITS + 1);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int MODE_W = $clog2(MODE_PULSES + 1);

  logic [SYNC_STAGES-1:0] latchSync, sclkSync, sdiSync;
  logic latchQ, sclkQ, latchPrev, sclkPrev;
  logic latchFall, sclkRise, sclkFall, active, fetchReq;
  logic frameOn, fetchQ, capRdQ;
  logic [CNT_W-1:0]  hdrCnt;
  logic [BIT_W-1:0]  dataBit;
  logic [MODE_W-1:0] modeCnt;
  logic inData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchSync <= '1;
      sclkSync  <= '0;
      sdiSync   <= '0;
      latchPrev <= 1'b1;
      sclkPrev  <= 1'b0;
    end else begin
      latchSync <= {latchSync[SYNC_STAGES-2:0], latchN};
      sclkSync  <= {sclkSync[SYNC_STAGES-2:0], sclk};
      sdiSync   <= {sdiSync[SYNC_STAGES-2:0], sdi};
      latchPrev <= latchQ;
      sclkPrev  <= sclkQ;
    end
  end

  assign latchQ    = latchSync[SYNC_STAGES-1];
  assign sclkQ     = sclkSync[SYNC_STAGES-1];
  assign sdiQ      = sdiSync[SYNC_STAGES-1];
  assign latchFall = latchPrev & ~latchQ;
  assign sclkRise  = sclkQ & ~sclkPrev;
  assign sclkFall  = ~sclkQ & sclkPrev;
  assign active    = frameOn & ~latchQ;
  assign inData    = (hdrCnt == CNT_W'(HDR_BITS));

  assign fetchReq = hdrMatch & hdrRead &
                    ((hdrCnt == CNT_W'(HDR_BITS - 1)) ||
                     (inData && dataBit == BIT_W'(BYTE_W - 1)));

  always_comb begin
    strb          = '0;
    strb.clrFrame = latchQ;
    strb.fetch    = fetchQ;
    strb.capRd    = capRdQ;
    if (active && sclkRise) begin
      strb.shiftIn = 1'b1;
      if (!inData) begin
        strb.capHdr = (hdrCnt == CNT_W'(BYTE_W - 1));
        strb.capSub = (hdrCnt == CNT_W'(HDR_BITS - 1));
      end else begin
        strb.wrStb = hdrMatch & ~hdrRead & (dataBit == BIT_W'(BYTE_W - 1));
      end
    end
    if (active && sclkFall && inData && hdrMatch && hdrRead) begin
      strb.oeSet    = 1'b1;
      strb.loadOut  = (dataBit == '0);
      strb.shiftOut = (dataBit != '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameOn <= 1'b0;
      hdrCnt  <= '0;
      dataBit <= '0;
      modeCnt <= '0;
      spiMode <= 1'b0;
      fetchQ  <= 1'b0;
      capRdQ  <= 1'b0;
    end else begin
      fetchQ <= active & sclkRise & fetchReq;
      capRdQ <= fetchQ;
      if (latchFall && !spiMode) begin
        if (modeCnt == MODE_W'(MODE_PULSES - 1)) spiMode <= 1'b1;
        else modeCnt <= modeCnt + 1'b1;
      end
      if (latchQ) begin
        frameOn <= 1'b0;
        hdrCnt  <= '0;
        dataBit <= '0;
      end else begin
        if (latchFall) frameOn <= spiMode;
        if (active && sclkRise) begin
          if (!inData) hdrCnt <= hdrCnt + 1'b1;
          else if (dataBit == BIT_W'(BYTE_W - 1)) dataBit <= '0;
          else dataBit <= dataBit + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_ctl_dp.sv
module spi_ctl_dp
  import spi_ctl_pkg::*;
#(
  parameter int SUB_W  = 12,
  parameter int BYTE_W = 8,
  parameter int CHIP_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              sdiQ,
  input  logic              addrSel,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              hdrMatch,
  output logic              hdrRead,
  output logic [SUB_W-1:0]  regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              sdo,
  output logic              sdoOe
);

  localparam int SH_W = SUB_W - 1;

  logic [SH_W-1:0]   shIn;
  logic [SUB_W-1:0]  curAddr;
  logic [BYTE_W-1:0] rdBuf, outShift;
  logic [CHIP_W-1:0] chipId;

  assign chipId    = {{(CHIP_W-1){1'b0}}, addrSel};
  assign regWrData = {shIn[BYTE_W-2:0], sdiQ};
  assign regAddr   = curAddr;
  assign sdo       = outShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shIn     <= '0;
      curAddr  <= '0;
      rdBuf    <= '0;
      outShift <= '0;
      hdrMatch <= 1'b0;
      hdrRead  <= 1'b0;
      sdoOe    <= 1'b0;
    end else begin
      if (strb.shiftIn) shIn <= {shIn[SH_W-2:0], sdiQ};
      if (strb.capHdr) begin
        hdrRead  <= sdiQ;
        hdrMatch <= (shIn[CHIP_W-1:0] == chipId);
      end
      if (strb.capSub) curAddr <= {shIn, sdiQ};
      else if (strb.wrStb || strb.fetch) curAddr <= curAddr + 1'b1;
      if (strb.capRd) rdBuf <= regRdData;
      if (strb.loadOut) outShift <= rdBuf;
      else if (strb.shiftOut) outShift <= {outShift[BYTE_W-2:0], 1'b0};
      if (strb.clrFrame) sdoOe <= 1'b0;
      else if (strb.oeSet) sdoOe <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int SUB_W       = 12,
  parameter int BYTE_W      = 8,
  parameter int CHIP_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_PULSES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              addrSel,
  output logic              sdo,
  output logic              sdoOe,
  output logic              spiMode,
  output logic [SUB_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [BYTE_W-1:0] regRdData
);

  localparam int SUB_BYTES = (SUB_W + BYTE_W - 1) / BYTE_W;
  localparam int HDR_BITS  = BYTE_W * (1 + SUB_BYTES);

  ctrlStrobes_t strb;
  logic sdiQ, hdrMatch, hdrRead;

  spi_ctl_fsm #(
    .SYNC_STAGES(SYNC_STAGES), .MODE_PULSES(MODE_PULSES),
    .HDR_BITS(HDR_BITS), .BYTE_W(BYTE_W)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .latchN(latchN), .sclk(sclk), .sdi(sdi),
    .hdrMatch(hdrMatch), .hdrRead(hdrRead),
    .sdiQ(sdiQ), .spiMode(spiMode), .strb(strb)
  );

  spi_ctl_dp #(
    .SUB_W(SUB_W), .BYTE_W(BYTE_W), .CHIP_W(CHIP_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiQ(sdiQ), .addrSel(addrSel),
    .regRdData(regRdData), .hdrMatch(hdrMatch), .hdrRead(hdrRead),
    .regAddr(regAddr), .regWrData(regWrData), .sdo(sdo), .sdoOe(sdoOe)
  );

  assign regWrEn = strb.wrStb;
  assign regRdEn = strb.fetch;

endmodule

// File: rtl/spi_ctl_port_chk.sv
module spi_ctl_port_chk (
  input logic clk,
  input logic rstN,
  input logic latchN,
  input logic spiMode,
  input logic sdoOe,
  input logic regWrEn,
  input logic regRdEn
);

  p_mode_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    spiMode |=> spiMode);

  p_no_strobe_i2c_r2: assert property (@(posedge clk) disable iff (!rstN)
    !spiMode |-> !(regWrEn || regRdEn));

  p_oe_needs_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> spiMode);

  p_wr_rd_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  p_oe_off_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (latchN && $past(latchN, 1) && $past(latchN, 2) && $past(latchN, 3)) |-> !sdoOe);

endmodule

bind spi_ctl_port spi_ctl_port_chk chk_i (
  .clk(clk), .rstN(rstN), .latchN(latchN), .spiMode(spiMode),
  .sdoOe(sdoOe), .regWrEn(regWrEn), .regRdEn(regRdEn)
);

// File: tb/spi_ctl_port_tb_top.sv
`timescale 1ns/1ps
module spi_ctl_port_tb_top;

  localparam int H = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, latchN, sclk, sdi, addrSel;
  logic sdo, sdoOe, spiMode, regWrEn, regRdEn;
  logic [11:0] regAddr;
  logic [7:0]  regWrData;
  logic [7:0]  regRdData = 8'h00;

  spi_ctl_port dut_i (
    .clk(clk), .rstN(rstN), .latchN(latchN), .sclk(sclk), .sdi(sdi),
    .addrSel(addrSel), .sdo(sdo), .sdoOe(sdoOe), .spiMode(spiMode),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData)
  );

  int checks = 0;
  int errors = 0;
  int wrSeen = 0;
  bit done = 1'b0;
  bit oeAllowed = 1'b0;
  bit rdFrame = 1'b0;
  logic [19:0] expWr[$];
  logic [11:0] expRd[$];
  logic [7:0]  txB[$];
  logic [7:0]  rxB[$];

  function automatic logic [7:0] rdVal(logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // register side model: read data valid the cycle after the read strobe
  always @(posedge clk) if (regRdEn) regRdData <= rdVal(regAddr);

  // per-cycle comparison against the expected strobe queues
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (regWrEn) begin
        wrSeen++;
        if (expWr.size() == 0) chk(1'b0, "R3 unexpected write", {regAddr, regWrData}, 0);
        else begin
          chk(expWr[0] == {regAddr, regWrData}, "R3/R4 write addr+data", {regAddr, regWrData}, expWr[0]);
          void'(expWr.pop_front());
        end
      end
      if (regRdEn) begin
        if (expRd.size() == 0) chk(1'b0, "R6 unexpected read", regAddr, 0);
        else begin
          chk(expRd[0] == regAddr, "R6/R7 read addr", regAddr, expRd[0]);
          void'(expRd.pop_front());
        end
      end
      if (sdoOe && !oeAllowed) chk(1'b0, "R8 oe outside read", 1, 0);
      if ((regWrEn || regRdEn) && !spiMode) chk(1'b0, "R2 strobe in default mode", 1, 0);
    end
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(int nbits);
    logic [7:0] cur;
    cur = '0;
    rxB.delete();
    latchN = 1'b0;
    waitN(H);
    for (int i = 0; i < nbits; i++) begin
      sdi = txB[i / 8][7 - (i % 8)];
      waitN(H);
      if (rdFrame && i >= 24) begin
        chk(sdoOe === 1'b1, "R8 oe during read data", sdoOe, 1);
        cur = {cur[6:0], sdo};
        if (i % 8 == 7) rxB.push_back(cur);
      end
      sclk = 1'b1;
      waitN(H);
      sclk = 1'b0;
    end
    waitN(H);
    latchN = 1'b1;
    waitN(4 * H);
  endtask

  task automatic pulse();
    latchN = 1'b0;
    waitN(H);
    latchN = 1'b1;
    waitN(H);
  endtask

  initial begin
    int w0;
    rstN = 1'b0; latchN = 1'b1; sclk = 1'b0; sdi = 1'b0; addrSel = 1'b0;
    waitN(5);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    chk(spiMode == 1'b0, "R1 spiMode after reset", spiMode, 0);
    chk(sdoOe == 1'b0, "R1 sdoOe after reset", sdoOe, 0);
    chk(!regWrEn && !regRdEn, "R1 no strobes after reset", {regWrEn, regRdEn}, 0);

    // R2 mode entry on third latch fall; the third frame itself is ignored
    pulse();
    pulse();
    chk(spiMode == 1'b0, "R2 still default after two pulses", spiMode, 0);
    txB = '{8'h00, 8'h01, 8'h23, 8'hAA};
    frame(32);
    chk(spiMode == 1'b1, "R2 mode entered after third pulse", spiMode, 1);
    chk(wrSeen == 0, "R2 entry frame wrote nothing", wrSeen, 0);

    // R3 single write
    txB = '{8'h00, 8'h01, 8'h23, 8'h5A};
    expWr.push_back({12'h123, 8'h5A});
    frame(32);
    chk(expWr.size() == 0, "R3 single write seen", expWr.size(), 0);

    // R4 burst write with index wrap
    txB = '{8'h00, 8'h0F, 8'hFE, 8'h11, 8'h22, 8'h33};
    expWr.push_back({12'hFFE, 8'h11});
    expWr.push_back({12'hFFF, 8'h22});
    expWr.push_back({12'h000, 8'h33});
    frame(48);
    chk(expWr.size() == 0, "R4 burst writes seen", expWr.size(), 0);

    // R5 chip address mismatch (write and read), then match with strap high
    w0 = wrSeen;
    txB = '{8'h02, 8'h01, 8'h00, 8'h77};
    frame(32);
    chk(wrSeen == w0, "R5 mismatched write ignored", wrSeen, w0);
    txB = '{8'h03, 8'h02, 8'h00, 8'h00};
    frame(32);
    chk(sdoOe == 1'b0, "R5 mismatched read keeps oe low", sdoOe, 0);
    addrSel = 1'b1;
    waitN(4);
    txB = '{8'h02, 8'h03, 8'h30, 8'h99};
    expWr.push_back({12'h330, 8'h99});
    frame(32);
    chk(expWr.size() == 0, "R5 strap-high address accepted", expWr.size(), 0);
    addrSel = 1'b0;
    waitN(4);

    // R6 single read
    rdFrame = 1'b1; oeAllowed = 1'b1;
    txB = '{8'h01, 8'h04, 8'h56, 8'h00};
    expRd.push_back(12'h456);
    expRd.push_back(12'h457);
    frame(32);
    rdFrame = 1'b0; oeAllowed = 1'b0;
    chk(rxB.size() == 1 && rxB[0] == rdVal(12'h456), "R6 first read byte", rxB.size() > 0 ? rxB[0] : 8'hxx, rdVal(12'h456));
    chk(sdoOe == 1'b0, "R8 oe released after read", sdoOe, 0);

    // R7 burst read
    rdFrame = 1'b1; oeAllowed = 1'b1;
    txB = '{8'h01, 8'h0A, 8'h10, 8'h00, 8'h00, 8'h00};
    for (int k = 0; k < 4; k++) expRd.push_back(12'hA10 + 12'(k));
    frame(48);
    rdFrame = 1'b0; oeAllowed = 1'b0;
    for (int k = 0; k < 3; k++)
      chk(rxB.size() == 3 && rxB[k] == rdVal(12'hA10 + 12'(k)), "R7 burst read byte",
          rxB.size() > k ? rxB[k] : 8'hxx, rdVal(12'hA10 + 12'(k)));
    chk(expRd.size() == 0, "R7 all fetches seen", expRd.size(), 0);

    // R9 truncated frames
    w0 = wrSeen;
    txB = '{8'h00, 8'h02, 8'h00, 8'hEE, 8'h00};
    frame(29);
    chk(wrSeen == w0, "R9 partial byte not written", wrSeen, w0);
    txB = '{8'h00, 8'h02, 8'h10, 8'h44, 8'h55};
    expWr.push_back({12'h210, 8'h44});
    frame(35);
    chk(wrSeen == w0 + 1 && expWr.size() == 0, "R9 completed byte kept, partial dropped", wrSeen, w0 + 1);

    // R10 upper nibble of byte 1 ignored
    txB = '{8'h00, 8'hF1, 8'h23, 8'h66};
    expWr.push_back({12'h123, 8'h66});
    frame(32);
    chk(expWr.size() == 0, "R10 upper nibble ignored", expWr.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule